// File: doc/BRIEF.md
# Macro Processor Execution Unit

This unit executes one decoded instruction of a small macro processor. It receives the operation class, an ALU function code, two register operands, a signed immediate and three bitfield parameters: a source bit, a destination bit and a field size. It returns a 32-bit result together with a flag for unsupported codes. The unit covers the following operations:

- two-operand arithmetic and logic operations,
- add-immediate,
- a field insert,
- two extract-and-shift forms, in which one of the two shift amounts is taken from a register operand,
- a read from an external register file over a simple request/response port.

The unit does not sequence instructions, does not store registers and does not route results. These jobs belong to the surrounding processor.

Every operation except a read gives its result one cycle after it is accepted. A read does not finish in that cycle. It sends one request pulse that carries the computed address, and it holds the input side not-ready until the response arrives. The returned word is presented as the result one cycle later.

Top module: `macro_exec_unit`

## Requirements
- R1: While reset is asserted and just after it is released, `out_valid` and `rd_req_valid` are 0 and `in_ready` is 1.
- R2: With `op_sel`=0 (ALU), the `alu_fn` codes produce the following results one cycle after acceptance, with `out_unsup`=0. Addition and subtraction wrap modulo 2^32.

  | `alu_fn` | Result |
  |---|---|
  | 0 | A+B |
  | 2 | A−B |
  | 8 | A xor B |
  | 9 | A or B |
  | 10 | A and B |
  | 11 | A and not B |
  | 12 | not(A and B) |
- R3: `op_sel`=1 gives A plus the 14-bit immediate, which is sign-extended before the addition.
- R4: `op_sel`=2 (insert) takes `size` bits of B starting at `src_bit`. It writes them into A at `dst_bit` and keeps every other bit of A.
- R5: `op_sel`=3 shifts B right by A, masks the result to `size` bits, then shifts it left by `dst_bit`.
- R6: `op_sel`=4 shifts B right by `src_bit`, masks the result to `size` bits, then shifts it left by A.
- R7: The field mask is (1<<size)−1, so a size of 0 gives an empty field. Shift amounts taken from A use only the low 5 bits of A.
- R8: `op_sel`=5 (read) behaves as follows:
  - In the cycle after acceptance, `rd_req_valid` pulses for exactly one cycle, with `rd_req_addr` = A plus the sign-extended immediate.
  - `in_ready` stays 0 until a cycle in which `rd_rsp_valid` is 1.
  - One cycle after that response, `out_valid` is 1 and `out_result` carries `rd_rsp_data`.
- R9: The following codes give `out_valid` with `out_result`=0 and `out_unsup`=1:
  - `alu_fn` 1 (add with carry),
  - `alu_fn` 3 (subtract with borrow),
  - any other `alu_fn` code not listed in R2,
  - `op_sel` 6 and 7.
- R10: `in_valid` has no effect while `in_ready` is 0, and `rd_rsp_valid` has no effect while no read is outstanding. In both cases `out_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Unit can accept an instruction |
| op_sel | input | 3 | Operation class |
| alu_fn | input | 5 | ALU function code |
| opnd_a | input | 32 | Register operand A |
| opnd_b | input | 32 | Register operand B |
| imm | input | 14 | Signed immediate |
| src_bit | input | 5 | Bitfield source position |
| dst_bit | input | 5 | Bitfield destination position |
| fld_size | input | 5 | Bitfield width |
| rd_req_valid | output | 1 | External read request pulse |
| rd_req_addr | output | 32 | External read address |
| rd_rsp_valid | input | 1 | External read response strobe |
| rd_rsp_data | input | 32 | External read data |
| out_valid | output | 1 | Result valid |
| out_result | output | 32 | Result |
| out_unsup | output | 1 | Unsupported code flag |

## Verification
The ALU functions are tried with complementary byte patterns. With these patterns, xor, and, and-not and nand each give a distinct word, and a mix-up between any two of them would show. Add and subtract are tried across the carry wrap, and add-immediate is tried with both a positive and a negative immediate, so a missing sign extension would show. The bitfield forms use fields with nonzero source and destination offsets, a one-bit field at bit 31, a 31-bit field and a zero-size field, with register shift amounts above 31. These cases separate the right-shift amount from the left-shift amount, show whether the rest of A is kept, and show whether the mask and shift truncation are correct. The read is checked for request timing, the address with a negative offset, the busy lockout and a stray response.

// File: rtl/macro_exec_pkg.sv
package macro_exec_pkg;
  localparam int DATA_W = 32;
  localparam int IMM_W  = 14;
  localparam int SH_W   = $clog2(DATA_W);

  typedef enum logic [2:0] {
    OP_ALU      = 3'd0,
    OP_ADDI     = 3'd1,
    OP_INSERT   = 3'd2,
    OP_EXT_SHLI = 3'd3,
    OP_EXT_SHLR = 3'd4,
    OP_READ     = 3'd5
  } op_e;

  typedef enum logic [4:0] {
    FN_ADD  = 5'd0,
    FN_ADDC = 5'd1,
    FN_SUB  = 5'd2,
    FN_SUBB = 5'd3,
    FN_XOR  = 5'd8,
    FN_OR   = 5'd9,
    FN_AND  = 5'd10,
    FN_ANDN = 5'd11,
    FN_NAND = 5'd12
  } alu_fn_e;
endpackage

// File: rtl/mx_alu.sv
module mx_alu
  import macro_exec_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [4:0]   fn,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res,
  output logic         unsup
);
  always_comb begin
    unsup = 1'b0;
    case (fn)
      FN_ADD:  res = a + b;
      FN_SUB:  res = a - b;
      FN_XOR:  res = a ^ b;
      FN_OR:   res = a | b;
      FN_AND:  res = a & b;
      FN_ANDN: res = a & ~b;
      FN_NAND: res = ~(a & b);
      default: begin
        res   = '0;
        unsup = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/mx_bitfield.sv
module mx_bitfield
  import macro_exec_pkg::*;
#(
  parameter int W  = DATA_W,
  parameter int SW = SH_W
) (
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  input  logic [SW-1:0] src_bit,
  input  logic [SW-1:0] dst_bit,
  input  logic [SW-1:0] size,
  output logic [W-1:0]  ins_res,
  output logic [W-1:0]  shli_res,
  output logic [W-1:0]  shlr_res
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0]  mask;
  logic [SW-1:0] a_amt;

  always_comb begin
    mask     = (ONE << size) - ONE;
    a_amt    = a[SW-1:0];
    ins_res  = (a & ~(mask << dst_bit)) | (((b >> src_bit) & mask) << dst_bit);
    shli_res = ((b >> a_amt) & mask) << dst_bit;
    shlr_res = ((b >> src_bit) & mask) << a_amt;
  end
endmodule

// File: rtl/mx_read_port.sv
module mx_read_port
  import macro_exec_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] addr_in,
  input  logic         rsp_valid,
  input  logic [W-1:0] rsp_data,
  output logic         busy,
  output logic         req_valid,
  output logic [W-1:0] req_addr,
  output logic         done,
  output logic [W-1:0] done_data
);
  logic         busy_q, busy_d;
  logic         req_q, req_d;
  logic [W-1:0] addr_q;
  logic         addr_en;

  always_comb begin
    done    = busy_q & rsp_valid;
    busy_d  = busy_q;
    req_d   = 1'b0;
    addr_en = 1'b0;
    if (!busy_q && start) begin
      busy_d  = 1'b1;
      req_d   = 1'b1;
      addr_en = 1'b1;
    end else if (done) begin
      busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      req_q  <= req_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else if (addr_en) addr_q <= addr_in;
  end

  assign busy      = busy_q;
  assign req_valid = req_q;
  assign req_addr  = addr_q;
  assign done_data = rsp_data;

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !req_valid); // R8
  AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> busy); // R8
  AST_DONE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R8
endmodule

// File: rtl/macro_exec_unit.sv
module macro_exec_unit
  import macro_exec_pkg::*;
#(
  parameter int W  = DATA_W,
  parameter int IW = IMM_W,
  parameter int SW = SH_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [2:0]    op_sel,
  input  logic [4:0]    alu_fn,
  input  logic [W-1:0]  opnd_a,
  input  logic [W-1:0]  opnd_b,
  input  logic [IW-1:0] imm,
  input  logic [SW-1:0] src_bit,
  input  logic [SW-1:0] dst_bit,
  input  logic [SW-1:0] fld_size,
  output logic          rd_req_valid,
  output logic [W-1:0]  rd_req_addr,
  input  logic          rd_rsp_valid,
  input  logic [W-1:0]  rd_rsp_data,
  output logic          out_valid,
  output logic [W-1:0]  out_result,
  output logic          out_unsup
);
  logic [W-1:0] imm_ext, a_plus_imm;
  logic [W-1:0] alu_res, ins_res, shli_res, shlr_res;
  logic         alu_unsup;
  logic         busy, rd_done;
  logic [W-1:0] rd_data;
  logic         accept, exec_now, start_rd;
  logic [W-1:0] exec_res, res_d;
  logic         exec_unsup, unsup_d, valid_d;
  logic         valid_q, unsup_q;
  logic [W-1:0] res_q;

  assign imm_ext    = {{(W-IW){imm[IW-1]}}, imm};
  assign a_plus_imm = opnd_a + imm_ext;

  mx_alu #(.W(W)) u_alu (
    .fn(alu_fn), .a(opnd_a), .b(opnd_b), .res(alu_res), .unsup(alu_unsup)
  );

  mx_bitfield #(.W(W), .SW(SW)) u_bitfield (
    .a(opnd_a), .b(opnd_b), .src_bit(src_bit), .dst_bit(dst_bit),
    .size(fld_size), .ins_res(ins_res), .shli_res(shli_res),
    .shlr_res(shlr_res)
  );

  assign in_ready = ~busy;
  assign accept   = in_valid & in_ready;
  assign start_rd = accept & (op_sel == OP_READ);
  assign exec_now = accept & (op_sel != OP_READ);

  mx_read_port #(.W(W)) u_read (
    .clk(clk), .rst_n(rst_n), .start(start_rd), .addr_in(a_plus_imm),
    .rsp_valid(rd_rsp_valid), .rsp_data(rd_rsp_data), .busy(busy),
    .req_valid(rd_req_valid), .req_addr(rd_req_addr), .done(rd_done),
    .done_data(rd_data)
  );

  always_comb begin
    exec_unsup = 1'b0;
    case (op_sel)
      OP_ALU: begin
        exec_res   = alu_res;
        exec_unsup = alu_unsup;
      end
      OP_ADDI:     exec_res = a_plus_imm;
      OP_INSERT:   exec_res = ins_res;
      OP_EXT_SHLI: exec_res = shli_res;
      OP_EXT_SHLR: exec_res = shlr_res;
      default: begin
        exec_res   = '0;
        exec_unsup = 1'b1;
      end
    endcase
  end

  always_comb begin
    valid_d = exec_now | rd_done;
    res_d   = rd_done ? rd_data : exec_res;
    unsup_d = rd_done ? 1'b0 : exec_unsup;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q   <= '0;
      unsup_q <= 1'b0;
    end else if (valid_d) begin
      res_q   <= res_d;
      unsup_q <= unsup_d;
    end
  end

  assign out_valid  = valid_q;
  assign out_result = res_q;
  assign out_unsup  = unsup_q;

  AST_ACCEPT_GIVES_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    exec_now |=> out_valid); // R2
  AST_UNSUP_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_unsup) |-> (out_result == '0)); // R9
  AST_BITFIELD_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_now && op_sel inside {OP_ADDI, OP_INSERT, OP_EXT_SHLI, OP_EXT_SHLR})
      |=> !out_unsup); // R9
  AST_QUIET_OTHERWISE: assert property (@(posedge clk) disable iff (!rst_n)
    (!exec_now && !rd_done) |=> !out_valid); // R10
endmodule

// File: tb/macro_exec_unit_bench.sv
module macro_exec_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready;
  logic [2:0]  op_sel;
  logic [4:0]  alu_fn;
  logic [31:0] opnd_a, opnd_b;
  logic [13:0] imm;
  logic [4:0]  src_bit, dst_bit, fld_size;
  logic        rd_req_valid;
  logic [31:0] rd_req_addr;
  logic        rd_rsp_valid;
  logic [31:0] rd_rsp_data;
  logic        out_valid;
  logic [31:0] out_result;
  logic        out_unsup;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #10 clk = ~clk;

  macro_exec_unit u_macro_exec_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_sel(op_sel), .alu_fn(alu_fn), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .imm(imm), .src_bit(src_bit), .dst_bit(dst_bit), .fld_size(fld_size),
    .rd_req_valid(rd_req_valid), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .out_valid(out_valid), .out_result(out_result), .out_unsup(out_unsup)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic [4:0]  fn;
    logic [31:0] a;
    logic [31:0] b;
    logic [13:0] im;
    logic [4:0]  sb;
    logic [4:0]  db;
    logic [4:0]  sz;
    logic [31:0] exp;
    logic        unsup;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{3'd0, 5'd0,  32'h5,         32'h7,         14'h0,    5'd0,  5'd0, 5'd0,  32'hC,         1'b0, 4'd2}, // R2 add
    '{3'd0, 5'd0,  32'hFFFF_FFFF, 32'h2,         14'h0,    5'd0,  5'd0, 5'd0,  32'h1,         1'b0, 4'd2}, // R2 add wrap
    '{3'd0, 5'd2,  32'h3,         32'h5,         14'h0,    5'd0,  5'd0, 5'd0,  32'hFFFF_FFFE, 1'b0, 4'd2}, // R2 sub
    '{3'd0, 5'd8,  32'hF0F0_F0F0, 32'hFF00_FF00, 14'h0,    5'd0,  5'd0, 5'd0,  32'h0FF0_0FF0, 1'b0, 4'd2}, // R2 xor
    '{3'd0, 5'd9,  32'h1200_0034, 32'h0056_7800, 14'h0,    5'd0,  5'd0, 5'd0,  32'h1256_7834, 1'b0, 4'd2}, // R2 or
    '{3'd0, 5'd10, 32'hF0F0_F0F0, 32'hFF00_FF00, 14'h0,    5'd0,  5'd0, 5'd0,  32'hF000_F000, 1'b0, 4'd2}, // R2 and
    '{3'd0, 5'd11, 32'hF0F0_F0F0, 32'hFF00_FF00, 14'h0,    5'd0,  5'd0, 5'd0,  32'h00F0_00F0, 1'b0, 4'd2}, // R2 and-not
    '{3'd0, 5'd12, 32'hF0F0_F0F0, 32'hFF00_FF00, 14'h0,    5'd0,  5'd0, 5'd0,  32'h0FFF_0FFF, 1'b0, 4'd2}, // R2 nand
    '{3'd1, 5'd0,  32'h100,       32'h0,         14'h0005, 5'd0,  5'd0, 5'd0,  32'h105,       1'b0, 4'd3}, // R3 positive
    '{3'd1, 5'd0,  32'h100,       32'h0,         14'h3FFF, 5'd0,  5'd0, 5'd0,  32'hFF,        1'b0, 4'd3}, // R3 negative
    '{3'd2, 5'd0,  32'hFFFF_FFFF, 32'hA5,        14'h0,    5'd4,  5'd8, 5'd4,  32'hFFFF_FAFF, 1'b0, 4'd4}, // R4
    '{3'd2, 5'd0,  32'h0,         32'h8000_0000, 14'h0,    5'd31, 5'd0, 5'd1,  32'h1,         1'b0, 4'd4}, // R4 top bit
    '{3'd3, 5'd0,  32'h8,         32'hAB00,      14'h0,    5'd0,  5'd4, 5'd8,  32'hAB0,       1'b0, 4'd5}, // R5
    '{3'd3, 5'd0,  32'h0,         32'hFFFF_FFFF, 14'h0,    5'd0,  5'd1, 5'd31, 32'hFFFF_FFFE, 1'b0, 4'd5}, // R5 wide field
    '{3'd3, 5'd0,  32'h24,        32'hF0,        14'h0,    5'd0,  5'd0, 5'd4,  32'hF,         1'b0, 4'd7}, // R7 low 5 bits of A
    '{3'd4, 5'd0,  32'h10,        32'hC3,        14'h0,    5'd0,  5'd0, 5'd8,  32'h00C3_0000, 1'b0, 4'd6}, // R6
    '{3'd4, 5'd0,  32'h23,        32'h1F0,       14'h0,    5'd4,  5'd0, 5'd5,  32'hF8,        1'b0, 4'd7}, // R7 low 5 bits of A
    '{3'd2, 5'd0,  32'h1234_5678, 32'hFFFF_FFFF, 14'h0,    5'd0,  5'd0, 5'd0,  32'h1234_5678, 1'b0, 4'd7}, // R7 empty insert
    '{3'd4, 5'd0,  32'h0,         32'hFFFF_FFFF, 14'h0,    5'd0,  5'd0, 5'd0,  32'h0,         1'b0, 4'd7}, // R7 empty extract
    '{3'd0, 5'd1,  32'h1,         32'h1,         14'h0,    5'd0,  5'd0, 5'd0,  32'h0,         1'b1, 4'd9}, // R9 add-carry
    '{3'd0, 5'd3,  32'h5,         32'h1,         14'h0,    5'd0,  5'd0, 5'd0,  32'h0,         1'b1, 4'd9}, // R9 sub-borrow
    '{3'd0, 5'd5,  32'h5,         32'h1,         14'h0,    5'd0,  5'd0, 5'd0,  32'h0,         1'b1, 4'd9}, // R9 unknown fn
    '{3'd6, 5'd0,  32'h5,         32'h1,         14'h1,    5'd0,  5'd0, 5'd0,  32'h0,         1'b1, 4'd9}, // R9 op 6
    '{3'd7, 5'd0,  32'hFFFF_FFFF, 32'h1,         14'h1,    5'd1,  5'd1, 5'd1,  32'h0,         1'b1, 4'd9}  // R9 op 7
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  task automatic drive(input vec_t v);
    op_sel = v.op; alu_fn = v.fn; opnd_a = v.a; opnd_b = v.b;
    imm = v.im; src_bit = v.sb; dst_bit = v.db; fld_size = v.sz;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below 5000", cycles);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; rd_rsp_valid = 1'b0; rd_rsp_data = '0;
    drive('0);
    repeat (3) @(negedge clk);
    // R1 state in reset
    check(!out_valid && !rd_req_valid && in_ready, "R1", "reset outputs",
          {29'b0, out_valid, rd_req_valid, in_ready}, 32'h1);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && !rd_req_valid && in_ready, "R1", "after release",
          {29'b0, out_valid, rd_req_valid, in_ready}, 32'h1);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check(out_valid, $sformatf("R%0d", VEC[i].req), $sformatf("vec %0d valid", i),
            {31'b0, out_valid}, 32'h1);
      check(out_result == VEC[i].exp, $sformatf("R%0d", VEC[i].req),
            $sformatf("vec %0d result", i), out_result, VEC[i].exp);
      check(out_unsup == VEC[i].unsup, $sformatf("R%0d", VEC[i].req),
            $sformatf("vec %0d flag", i), {31'b0, out_unsup}, {31'b0, VEC[i].unsup});
      @(negedge clk);
    end

    // R8 read with negative offset: 0x100 - 4
    drive('{3'd5, 5'd0, 32'h100, 32'h0, 14'h3FFC, 5'd0, 5'd0, 5'd0, 32'h0, 1'b0, 4'd8});
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(rd_req_valid && rd_req_addr == 32'hFC, "R8", "request addr",
          rd_req_addr, 32'hFC);
    check(!in_ready && !out_valid, "R8", "busy, no result",
          {30'b0, in_ready, out_valid}, 32'h0);
    // R10 instruction while busy is dropped
    drive('{3'd0, 5'd0, 32'h1, 32'h1, 14'h0, 5'd0, 5'd0, 5'd0, 32'h0, 1'b0, 4'd10});
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(!rd_req_valid, "R8", "request is one pulse", {31'b0, rd_req_valid}, 32'h0);
    check(!out_valid && !in_ready, "R10", "busy input ignored",
          {30'b0, out_valid, in_ready}, 32'h0);
    @(negedge clk);
    check(!out_valid && !in_ready, "R8", "waits for response",
          {30'b0, out_valid, in_ready}, 32'h0);
    rd_rsp_valid = 1'b1; rd_rsp_data = 32'hDEAD_BEEF;
    @(negedge clk);
    rd_rsp_valid = 1'b0; rd_rsp_data = '0;
    check(out_valid && out_result == 32'hDEAD_BEEF && !out_unsup, "R8", "read result",
          out_result, 32'hDEAD_BEEF);
    check(in_ready, "R8", "ready after response", {31'b0, in_ready}, 32'h1);
    @(negedge clk);
    check(!out_valid, "R10", "no result after busy drop", {31'b0, out_valid}, 32'h0);

    // R10 stray response while idle
    rd_rsp_valid = 1'b1; rd_rsp_data = 32'h1234_0000;
    @(negedge clk);
    rd_rsp_valid = 1'b0;
    check(!out_valid && out_result == 32'hDEAD_BEEF, "R10", "stray response ignored",
          out_result, 32'hDEAD_BEEF);
    @(negedge clk);
    finish_run();
  end
endmodule